// File: doc/BRIEF.md
# Dual-Gain Range-Extended SAR Controller

This block sequences one conversion of an analog channel whose dynamic range is widened by a gain stage in front of a successive-approximation converter. When a conversion starts, a range comparator result is captured. It selects either the gain-of-four path, for small inputs, or the unity path, for large inputs. That choice is held for the whole conversion and is driven out as the gain select.

The controller then runs a 14-decision search against a DAC. The trial weights shrink by a ratio below two, so later steps can absorb a wrong early decision. The first six decisions form a coarse stage and the last eight form a fine stage. The 12-bit result is the sum of the weights of the accepted decisions, clipped at full scale. The gain choice places this result inside a 14-bit code: unchanged in the low bits on the gain-of-four path, or moved up two positions on the unity path. A one-cycle valid strobe marks each new code.

Top module: `range_sar_ctrl`

## Requirements
- R1: After reset, valid_o, code_o, dac_trial_o and gain_x4_o are all 0.
- R2: A start seen on a clock edge while the block is idle captures range_cmp_i into gain_x4_o (1 = gain-of-four path). gain_x4_o then holds that value until the next accepted start.
- R3: During search step k (k = 0..13, one clock each, step 0 in the cycle after the accepting edge), dac_trial_o equals the sum of the weights accepted so far plus weight k. At that step's closing edge, sar_cmp_i = 1 accepts weight k. Outside the search, dac_trial_o is 0.
- R4: The step weights, in order, are 1810, 1000, 560, 320, 180, 100 (coarse stage, steps 0-5), then 56, 32, 18, 10, 6, 4, 2, 1 (fine stage, steps 6-13).
- R5: The conversion result is the sum of the accepted weights, clipped to 4095. Accepting every step gives 4095.
- R6: If gain_x4_o = 1, code_o[13:12] = 00 and code_o[11:0] holds the result. If gain_x4_o = 0, code_o[13:2] holds the result and code_o[1:0] = 00.
- R7: valid_o is high for exactly one cycle, after the 15th rising edge following the accepting edge. code_o holds its value until the next valid.
- R8: A start asserted from the accepting edge up to and including the edge that raises valid_o is ignored. Timing, gain select and code are unchanged.
- R9: With an ideal comparator, the result equals the SAR input for inputs 0..4095. It stays exact when coarse-stage decisions are biased toward 0 by up to 20 LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion start request |
| range_cmp_i | input | 1 | Range comparator, 1 = small signal, use gain-of-four |
| sar_cmp_i | input | 1 | SAR comparator, 1 = input at or above trial |
| dac_trial_o | output | 13 | DAC trial level for the current step |
| gain_x4_o | output | 1 | Selected gain path, 1 = gain-of-four |
| code_o | output | 14 | Assembled conversion code |
| valid_o | output | 1 | One-cycle strobe for a new code |

## Verification
Several properties are checked on every cycle:
- the gain select cannot move during a conversion;
- the step counter advances by one per cycle;
- valid lasts a single cycle;
- the code's fixed zero bits match the gain path;
- the running accumulator agrees with the weighted sum of the stored decisions.

Some behaviours only the bench's conversions can show:
- that an ideal or coarse-biased search lands exactly on the input;
- the clip at full scale;
- the exact trial levels per step;
- that starts arriving mid-conversion leave timing and results untouched.

// File: rtl/range_sar_pkg.sv
package range_sar_pkg;
  localparam int unsigned STEPS        = 14;
  localparam int unsigned COARSE_STEPS = 6;
  localparam int unsigned RES_W        = 12;
  localparam int unsigned CODE_W       = RES_W + 2;
  localparam int unsigned WT_W         = RES_W + 1;
  localparam int unsigned STEP_W       = $clog2(STEPS);

  typedef enum logic [1:0] {ST_IDLE, ST_CONV, ST_FIN} conv_state_e;

  // radix < 2: each weight <= sum of later weights + 1
  function automatic logic [WT_W-1:0] step_weight(input int unsigned idx);
    case (idx)
      0:  return WT_W'(1810);
      1:  return WT_W'(1000);
      2:  return WT_W'(560);
      3:  return WT_W'(320);
      4:  return WT_W'(180);
      5:  return WT_W'(100);
      6:  return WT_W'(56);
      7:  return WT_W'(32);
      8:  return WT_W'(18);
      9:  return WT_W'(10);
      10: return WT_W'(6);
      11: return WT_W'(4);
      12: return WT_W'(2);
      default: return WT_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/sar_weight_file.sv
module sar_weight_file
  import range_sar_pkg::*;
(
  input  logic [STEP_W-1:0]           step_i,
  output logic [STEPS-1:0][WT_W-1:0]  wt_all_o,
  output logic [WT_W-1:0]             wt_sel_o
);
  for (genvar g = 0; g < STEPS; g++) begin : g_wt
    if (g < COARSE_STEPS) begin : g_coarse
      assign wt_all_o[g] = step_weight(g);
    end else begin : g_fine
      assign wt_all_o[g] = step_weight(g);
    end
  end

  always_comb begin
    wt_sel_o = '0;
    for (int i = 0; i < STEPS; i++)
      if (step_i == STEP_W'(i)) wt_sel_o = wt_all_o[i];
  end
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
  import range_sar_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              range_cmp_i,
  input  logic              sar_cmp_i,
  input  logic [WT_W-1:0]   wt_sel_i,
  output logic [STEP_W-1:0] step_o,
  output logic [STEPS-1:0]  bits_o,
  output logic [WT_W-1:0]   acc_o,
  output logic [WT_W-1:0]   dac_o,
  output logic              gain_x4_o,
  output logic              finish_o
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(STEPS - 1);

  conv_state_e       state_q;
  logic [STEP_W-1:0] step_q;
  logic [STEPS-1:0]  bits_q;
  logic [WT_W-1:0]   acc_q;
  logic              gain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      bits_q  <= '0;
      acc_q   <= '0;
      gain_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          gain_q  <= range_cmp_i;
          step_q  <= '0;
          bits_q  <= '0;
          acc_q   <= '0;
          state_q <= ST_CONV;
        end
        ST_CONV: begin
          bits_q[step_q] <= sar_cmp_i;
          if (sar_cmp_i) acc_q <= acc_q + wt_sel_i;
          if (step_q == LAST) state_q <= ST_FIN;
          else                step_q  <= step_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign step_o    = step_q;
  assign bits_o    = bits_q;
  assign acc_o     = acc_q;
  assign gain_x4_o = gain_q;
  assign finish_o  = (state_q == ST_FIN);
  assign dac_o     = (state_q == ST_CONV) ? acc_q + wt_sel_i : '0;

  // R2
  gain_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> $stable(gain_q));
  // R3
  step_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV && step_q != LAST) |=> (step_q == $past(step_q) + 1'b1));
  // R8
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CONV && step_q != LAST) |=> (state_q == ST_CONV));
endmodule

// File: rtl/sar_code_merge.sv
module sar_code_merge
  import range_sar_pkg::*;
(
  input  logic [STEPS-1:0]           bits_i,
  input  logic [STEPS-1:0][WT_W-1:0] wt_all_i,
  input  logic                       gain_x4_i,
  output logic [WT_W-1:0]            sum_o,
  output logic [CODE_W-1:0]          code_o
);
  localparam logic [WT_W-1:0] FULL = WT_W'((1 << RES_W) - 1);

  logic [RES_W-1:0] res;

  always_comb begin
    sum_o = '0;
    for (int i = 0; i < STEPS; i++)
      if (bits_i[i]) sum_o = sum_o + wt_all_i[i];
  end

  assign res    = (sum_o > FULL) ? FULL[RES_W-1:0] : sum_o[RES_W-1:0];
  assign code_o = gain_x4_i ? {2'b00, res} : {res, 2'b00};
endmodule

// File: rtl/range_sar_ctrl.sv
module range_sar_ctrl
  import range_sar_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              range_cmp_i,
  input  logic              sar_cmp_i,
  output logic [WT_W-1:0]   dac_trial_o,
  output logic              gain_x4_o,
  output logic [CODE_W-1:0] code_o,
  output logic              valid_o
);
  logic [STEP_W-1:0]          step;
  logic [STEPS-1:0]           bits;
  logic [WT_W-1:0]            acc, wt_sel, sum;
  logic [STEPS-1:0][WT_W-1:0] wt_all;
  logic                       finish;
  logic [CODE_W-1:0]          code_d, code_q;
  logic                       valid_q;

  sar_weight_file u_wf (
    .step_i   (step),
    .wt_all_o (wt_all),
    .wt_sel_o (wt_sel)
  );

  sar_sequencer u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .range_cmp_i (range_cmp_i),
    .sar_cmp_i   (sar_cmp_i),
    .wt_sel_i    (wt_sel),
    .step_o      (step),
    .bits_o      (bits),
    .acc_o       (acc),
    .dac_o       (dac_trial_o),
    .gain_x4_o   (gain_x4_o),
    .finish_o    (finish)
  );

  sar_code_merge u_merge (
    .bits_i    (bits),
    .wt_all_i  (wt_all),
    .gain_x4_i (gain_x4_o),
    .sum_o     (sum),
    .code_o    (code_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= finish;
      if (finish) code_q <= code_d;
    end
  end

  assign code_o  = code_q;
  assign valid_o = valid_q;

  // R7
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
  // R6
  x4_top_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && gain_x4_o) |-> (code_q[CODE_W-1:CODE_W-2] == 2'b00));
  // R6
  unity_low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !gain_x4_o) |-> (code_q[1:0] == 2'b00));
  // R5
  acc_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish |-> (sum == acc));
  // R7
  code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(finish) |-> $stable(code_q));
endmodule

// File: tb/range_sar_ctrl_tb.sv
module range_sar_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        range_cmp = 1'b0;
  logic        sar_cmp = 1'b0;
  logic [12:0] dac;
  logic        gain_x4;
  logic [13:0] code;
  logic        valid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  range_sar_ctrl u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .range_cmp_i (range_cmp),
    .sar_cmp_i   (sar_cmp),
    .dac_trial_o (dac),
    .gain_x4_o   (gain_x4),
    .code_o      (code),
    .valid_o     (valid)
  );

  // R4 weight list
  function automatic int wt(input int k);
    int tbl[14] = '{1810, 1000, 560, 320, 180, 100, 56, 32, 18, 10, 6, 4, 2, 1};
    return tbl[k];
  endfunction

  function automatic int map_code(input int res, input bit x4);
    int r = (res > 4095) ? 4095 : res;
    return x4 ? r : (r << 2);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // off: coarse-stage bias toward 0; mid_start: stray start during search
  task automatic convert(input int vin, input int off, input bit mid_start, input bit all_ones);
    bit x4 = (vin < 4096);
    int sar_in = x4 ? vin : (vin >> 2);
    int acc_m = 0;
    int exp_code;
    bit c;
    @(negedge clk);
    start = 1'b1;
    range_cmp = x4;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    range_cmp = ~x4;
    check(gain_x4 == x4, "R2 gain capture", gain_x4, x4);
    for (int k = 0; k < 14; k++) begin
      if (k > 0) @(negedge clk);
      check(int'(dac) == acc_m + wt(k), "R3 trial level", dac, acc_m + wt(k));
      if (all_ones) c = 1'b1;
      else if (k < 6) c = (sar_in - off >= int'(dac));
      else c = (sar_in >= int'(dac));
      sar_cmp = c;
      if (mid_start && k == 5) start = 1'b1;
      else start = 1'b0;
      if (c) acc_m += wt(k);
      @(posedge clk);
    end
    @(negedge clk);
    start = mid_start;
    sar_cmp = 1'b0;
    check(valid == 1'b0, "R7 no early valid", valid, 0);
    check(int'(dac) == 0, "R3 trial idle", dac, 0);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    exp_code = all_ones ? map_code(4095, x4) : map_code(sar_in, x4);
    check(valid == 1'b1, "R7 valid rises", valid, 1);
    check(int'(code) == exp_code, all_ones ? "R5 clip" : (off > 0 ? "R9 redundancy" : "R6 code"),
          code, exp_code);
    check(gain_x4 == x4, "R8 gain unchanged", gain_x4, x4);
    @(negedge clk);
    check(valid == 1'b0, "R7 single pulse", valid, 0);
    check(int'(code) == exp_code, "R7 code held", code, exp_code);
    check(int'(dac) == 0, "R8 stray start ignored", dac, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    #1;
    check(valid == 0 && code == 0 && dac == 0 && gain_x4 == 0, "R1 reset", {valid, code}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(valid == 0 && code == 0 && dac == 0 && gain_x4 == 0, "R1 after reset", code, 0);

    convert(0, 0, 0, 0);        // R9 zero
    convert(4095, 0, 0, 0);     // R6 top of x4 range
    convert(4096, 0, 0, 0);     // R6 bottom of unity range
    convert(16383, 0, 0, 0);    // R6 unity full scale
    convert(4095, 0, 0, 1);     // R5 clip, x4
    convert(16383, 0, 0, 1);    // R5 clip, unity
    convert(2000, 20, 0, 0);    // R9 coarse bias
    convert(9000, 0, 1, 0);     // R8 stray start
    for (int i = 0; i < 60; i++)
      convert($urandom % 16384, (i % 3 == 0) ? ($urandom % 21) : 0, (i % 7 == 0), 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule